// File: doc/BRIEF.md
# Audio Sample Error Concealer with Zero-Cross Mute

This block cleans up a mono stream of 16-bit two's-complement audio samples, each arriving with a flag that marks it as uncorrectable. A flagged sample is replaced using the good samples around it. A lone flagged sample between two good ones becomes the mean of those two. In a run of flagged samples, the last good value is held, and the final flagged sample of the run becomes the mean of the held value and the good sample that follows. The concealed stream then passes through a mute stage. That stage switches between full level and silence only where the signal crosses zero, so the switch itself adds no click.

Samples enter through a valid/ready input. The block never stalls, so the ready output stays high. Every accepted sample shifts a one-sample look-ahead stage. Sample k is resolved when sample k+1 is accepted, and it appears on the registered output on the next clock edge. When bypass is selected, a second output carries the raw sample as it arrived, aligned with the concealed output and untouched by concealment or muting. Stereo or multi-channel use takes one instance per channel.

Top module: `sample_conceal`

## Requirements
- R1: A sample whose error flag is low is output unchanged. Sample k appears on `out_data`, with `out_valid` high, in the cycle after the clock edge that accepts sample k+1.
- R2: A flagged sample with good samples directly before and after it is output as the mean of those two. The mean is the 17-bit signed sum shifted right arithmetically by one, so it rounds toward negative infinity (for example, -3 and 0 give -2).
- R3: Inside a run of two or more flagged samples, every flagged sample except the last one before a good sample is output as the most recent good input value.
- R4: The last flagged sample of a run is output as the mean, computed as in R2, of the held good value and the good sample that follows it. This applies only when that following sample is the very next one accepted.
- R5: A flagged sample that arrives before any good sample has been seen since reset is output as zero.
- R6: The mute state takes the value of `mute_req` (1 = silence, 0 = full level) only on a sample whose concealed value has a different sign bit from the previous concealed sample. The sign reference is 0 after reset. The new state already applies to that sample.
- R7: While the mute state is 1, `out_data` is zero. While it is 0, `out_data` equals the concealed value.
- R8: `raw_valid` is high together with `out_valid` exactly when `bypass_sel` was high as the following sample was accepted. `raw_data` then holds the sample exactly as received, whatever its flag or the mute state.
- R9: After reset, `out_valid` and `raw_valid` are low, the mute state is 0, no good value is held, and `in_ready` is high.
- R10: `out_valid` is high for exactly one cycle per accepted sample after the first, and only in the cycle that follows an accepted sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Always high; the block never stalls |
| in_data | input | 16 | Signed input sample |
| in_err | input | 1 | Input sample is uncorrectable |
| mute_req | input | 1 | Requested mute level: 1 silence, 0 full level |
| bypass_sel | input | 1 | Also present the raw sample on the bypass output |
| out_valid | output | 1 | Concealed sample present |
| out_data | output | 16 | Concealed and muted sample |
| raw_valid | output | 1 | Raw bypass sample present |
| raw_data | output | 16 | Raw sample, not concealed and not muted |

## Verification
The corner cases targeted are these:
- a lone flagged sample between negative neighbours, where a design that divides with rounding toward zero gives -1 instead of -2;
- full-scale neighbours, where a 16-bit sum would wrap and flip the sign;
- runs of flagged samples, where a design could average every member or hold the last one, instead of holding and then averaging only the final member;
- flagged samples right after reset, where a design without a "seen a good value" flag would average against a stale zero.

Mute requests are raised while the signal keeps one sign, so a design that switches at once instead of waiting for a sign flip shows zeros too early. Bypass samples are checked against flagged inputs while mute is active, which catches any leak of concealment or muting into the raw path.

// File: rtl/interp_pkg.sv
package interp_pkg;

    localparam int SMP_W = 16;
    localparam int SUM_W = SMP_W + 1;

    typedef logic [SMP_W-1:0] smp_t;

    typedef struct packed {
        logic bad;
        smp_t val;
    } flagged_smp_t;

    // Mean of two signed samples: widen, add, arithmetic shift right by one.
    function automatic smp_t mean2(input smp_t a, input smp_t b);
        logic signed [SUM_W-1:0] s;
        s = $signed({a[SMP_W-1], a}) + $signed({b[SMP_W-1], b});
        return s[SUM_W-1:1];
    endfunction

endpackage

// File: rtl/conceal_pick.sv
module conceal_pick
    import interp_pkg::*;
(
    input  flagged_smp_t cur,
    input  flagged_smp_t nxt,
    input  smp_t         held,
    input  logic         held_ok,
    output smp_t         fixed
);
    always_comb begin
        if (!cur.bad) begin
            fixed = cur.val;
        end else if (!held_ok) begin
            fixed = '0;
        end else if (!nxt.bad) begin
            fixed = mean2(held, nxt.val);
        end else begin
            fixed = held;
        end
    end
endmodule

// File: rtl/zc_mute.sv
module zc_mute
    import interp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic req,
    input  smp_t din,
    output smp_t dout,
    output logic state
);
    logic state_q, state_nx;
    logic sign_q;
    logic crossed;

    assign crossed  = din[SMP_W-1] != sign_q;
    assign state_nx = (crossed && (req != state_q)) ? req : state_q;
    assign dout     = state_nx ? '0 : din;
    assign state    = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= 1'b0;
            sign_q  <= 1'b0;
        end else if (step) begin
            state_q <= state_nx;
            sign_q  <= din[SMP_W-1];
        end
    end
endmodule

// File: rtl/sample_conceal.sv
module sample_conceal
    import interp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SMP_W-1:0] in_data,
    input  logic             in_err,
    input  logic             mute_req,
    input  logic             bypass_sel,
    output logic             out_valid,
    output logic [SMP_W-1:0] out_data,
    output logic             raw_valid,
    output logic [SMP_W-1:0] raw_data
);
    flagged_smp_t stage_q, incoming;
    logic         stage_full;
    smp_t         held_q;
    logic         held_ok_q;
    smp_t         fixed, muted_val;
    logic         step;
    logic         mute_st;

    assign in_ready = 1'b1;
    assign incoming = '{bad: in_err, val: in_data};
    assign step     = in_valid && stage_full;

    conceal_pick u_pick (
        .cur     (stage_q),
        .nxt     (incoming),
        .held    (held_q),
        .held_ok (held_ok_q),
        .fixed   (fixed)
    );

    zc_mute u_mute (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .req   (mute_req),
        .din   (fixed),
        .dout  (muted_val),
        .state (mute_st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q    <= '0;
            stage_full <= 1'b0;
            held_q     <= '0;
            held_ok_q  <= 1'b0;
            out_valid  <= 1'b0;
            out_data   <= '0;
            raw_valid  <= 1'b0;
            raw_data   <= '0;
        end else begin
            out_valid <= step;
            raw_valid <= step && bypass_sel;
            if (step) begin
                out_data <= muted_val;
                raw_data <= stage_q.val;
                if (!stage_q.bad) begin
                    held_q    <= stage_q.val;
                    held_ok_q <= 1'b1;
                end
            end
            if (in_valid) begin
                stage_q    <= incoming;
                stage_full <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sample_conceal_chk.sv
module sample_conceal_chk
    import interp_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       mute_req,
    input logic       out_valid,
    input smp_t       out_data,
    input logic       raw_valid,
    input logic       mute_st
);
    // R10
    out_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R8
    raw_with_out_chk: assert property (@(posedge clk) disable iff (rst)
        raw_valid |-> out_valid);

    // R6
    mute_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mute_st) |-> (mute_st == $past(mute_req)) && $past(in_valid));

    // R7
    muted_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && mute_st) |-> (out_data == '0));

    // R9
    ready_high_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready);
endmodule

bind sample_conceal sample_conceal_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .mute_req  (mute_req),
    .out_valid (out_valid),
    .out_data  (out_data),
    .raw_valid (raw_valid),
    .mute_st   (mute_st)
);

// File: tb/sim_sample_conceal.sv
`timescale 1ns/1ps
module sim_sample_conceal;
    localparam int NMAX = 1200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_err = 1'b0, mute_req = 1'b0, bypass_sel = 1'b0;
    logic [15:0] in_data = '0;
    logic in_ready, out_valid, raw_valid;
    logic [15:0] out_data, raw_data;

    always #2.5 clk = ~clk;

    sample_conceal u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_err(in_err), .mute_req(mute_req),
        .bypass_sel(bypass_sel), .out_valid(out_valid), .out_data(out_data),
        .raw_valid(raw_valid), .raw_data(raw_data)
    );

    int vecs = 0, fails = 0;
    bit done = 1'b0;
    logic [15:0] xs [NMAX];
    logic        es [NMAX];
    int          n = 0;
    logic        m_state = 0, m_sign = 0;

    function automatic logic [15:0] avg(input logic [15:0] a, input logic [15:0] b);
        int s;
        s = int'($signed(a)) + int'($signed(b));
        return 16'(s >>> 1);
    endfunction

    // Expected concealed value of sample k, given sample k+1 is known.
    function automatic logic [15:0] conceal_exp(input int k);
        int j;
        if (!es[k]) return xs[k];
        j = k - 1;
        while (j >= 0 && es[j]) j--;
        if (j < 0) return 16'h0;                     // R5
        if (!es[k+1]) return avg(xs[j], xs[k+1]);    // R2, R4
        return xs[j];                                // R3
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Send one sample; the output of the previous sample is checked.
    task automatic send(input logic [15:0] d, input logic e, input logic m, input logic b);
        logic [15:0] c, ex;
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_err = e; mute_req = m; bypass_sel = b;
        xs[n] = d; es[n] = e;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        if (n == 0) begin
            chk("R10 no output for first sample", {31'b0, out_valid}, 32'd0);
        end else begin
            c = conceal_exp(n - 1);
            if ((c[15] != m_sign) && (m != m_state)) m_state = m;  // R6
            m_sign = c[15];
            ex = m_state ? 16'h0 : c;                              // R7
            chk("R10 out_valid", {31'b0, out_valid}, 32'd1);
            chk("R1-R7 out_data", {16'b0, out_data}, {16'b0, ex});
            chk("R8 raw_valid", {31'b0, raw_valid}, {31'b0, b});
            if (b) chk("R8 raw_data", {16'b0, raw_data}, {16'b0, xs[n-1]});
        end
        n++;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R9 reset state
        chk("R9 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R9 raw_valid", {31'b0, raw_valid}, 32'd0);
        chk("R9 in_ready", {31'b0, in_ready}, 32'd1);

        // R5: flagged samples before any good one give zero
        send(16'h1234, 1, 0, 1);
        send(16'h5555, 1, 0, 1);
        send(16'd100, 0, 0, 0);
        // R2: isolated flag, negative neighbours, floor rounding: -3 and 0 -> -2
        send(16'hFFFD, 0, 0, 0);
        send(16'h7777, 1, 0, 1);
        send(16'd0, 0, 0, 0);
        // R2 full scale: no wrap
        send(16'h7FFF, 0, 0, 0);
        send(16'h0001, 1, 0, 0);
        send(16'h7FFF, 0, 0, 0);
        send(16'h8000, 0, 0, 0);
        send(16'h0001, 1, 0, 0);
        send(16'h8000, 0, 0, 0);
        // R3/R4: run of four then good
        send(16'd400, 0, 0, 0);
        send(16'd9, 1, 0, 1);
        send(16'd9, 1, 0, 0);
        send(16'd9, 1, 0, 0);
        send(16'd9, 1, 0, 1);
        send(16'd1000, 0, 0, 0);
        // R6: mute request while sign stays positive, then a sign flip
        send(16'd50, 0, 1, 0);
        send(16'd60, 0, 1, 0);
        send(16'd70, 0, 1, 1);
        send(16'hFF00, 0, 1, 1);
        send(16'hFE00, 1, 1, 1);  // R8 raw during mute and flag
        send(16'hFD00, 0, 1, 0);
        // unmute waits for the next crossing
        send(16'hFC00, 0, 0, 0);
        send(16'd5, 0, 0, 0);
        send(16'd6, 0, 0, 0);

        // random stimulus with bursts of flags
        for (int i = 0; i < 900; i++) begin
            logic [15:0] d;
            logic e, m, b;
            d = 16'($urandom);
            if ($urandom_range(0, 3) == 0) d = 16'($signed(16'($urandom_range(0, 15))) - 16'sd8);
            e = ($urandom_range(0, 99) < 30);
            m = ($urandom_range(0, 99) < 20);
            b = $urandom_range(0, 1) == 1;
            if ($urandom_range(0, 2) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
            send(d, e, m, b);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule